// File: doc/BRIEF.md
# Per-Processor Interrupt Presentation Controller

This block sits between a bank of interrupt sources and one processor. It holds the processor's current priority threshold, a software-programmable inter-processor-interrupt (IPI) priority, the single source number currently presented to the processor together with its pending priority, and a flag recording that some offer was refused. In all priority fields a lower number means a more favored priority, and 0xff is the least favored.

Sources offer an interrupt as a source number and a priority. The controller takes the offer or refuses it. When a presented source is displaced, either by a better offer, by raising the threshold or by the IPI, the controller hands that source back as rejected, so the bank can offer it again. The processor drives one operation per cycle: accept, write threshold, end-of-interrupt (EOI), write IPI priority, or poll. Each operation is applied atomically in one clock. Every result appears on registered outputs one cycle after the request. A level interrupt output tells the processor that something worth taking is presented.

The source number 2 is reserved for the IPI and is never reported as rejected. The source numbers 0 and 2 are never taken as external offers.

Top module: `irq_present_ctrl`

## Requirements
- R1: After synchronous reset the threshold and the presented source are 0, the IPI priority and the pending priority are 0xff, the refusal flag is clear and `irq_out` is low.
- R2: An offer with a source number other than 0 or 2 is taken (`offer_taken`=1) only when its priority is strictly below the threshold, the IPI priority and the pending priority. A refused valid-source offer sets the refusal flag. Offers of source 0 or 2 are refused and leave the flag unchanged.
- R3: A taken offer replaces the presented source and its pending priority. A displaced source other than 0 and 2 is reported on `rej_valid`/`rej_src`; a displaced IPI is not reported.
- R4: `irq_out` is high exactly when the presented source is nonzero and the pending priority is below the threshold.
- R5: Accept (`op_code`=1) returns `rsp_word` = {threshold[31:24], source[23:0]} and the IPI priority on `rsp_ipi_prio`. If the source was nonzero, the threshold takes the pending priority, the pending priority becomes 0xff and the source is cleared.
- R6: Threshold write (`op_code`=2, new value in `op_arg`[7:0]) to a lower number loads it and, if the new value is no greater than the pending priority, rejects the presented source and empties the slot. Writing the current value changes nothing and emits nothing.
- R7: Threshold write to a higher number loads it. If the IPI priority is below the new threshold and no greater than the pending priority, the IPI (source 2) is presented at the IPI priority. The refusal flag is cleared, and `resend_req` pulses if it was set.
- R8: IPI priority write (`op_code`=4, value in `op_arg`[7:0]) stores it. If it is below the threshold, the IPI is presented at that priority, and the old source is rejected when the new value is no greater than the old pending priority. If the new value is larger than the old IPI priority and larger than the threshold, the refusal flag is cleared and `resend_req` pulses if it was set.
- R9: EOI (`op_code`=3) applies `op_arg`[31:24] through the R7 raising-number path, whatever the current threshold. It reports `op_arg`[23:0] on `eoi_valid`/`eoi_src` unless that value is 2.
- R10: Poll (`op_code`=5) returns the same `rsp_word` and `rsp_ipi_prio` as accept and changes no state.
- R11: An offer in the same cycle as accept, threshold write, EOI or IPI write is refused. If the offer has a valid source, it sets the refusal flag after the operation. An offer in the same cycle as poll, or with no operation, is evaluated normally against the state before the cycle.
- R12: `op_code` 0, 6 and 7 do nothing. All outputs except `irq_out` are registered, and they show the effect of a request one clock after it is presented.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| offer_valid | input | 1 | An interrupt offer is presented this cycle |
| offer_src | input | 24 | Offered source number |
| offer_prio | input | 8 | Offered priority |
| op_code | input | 3 | Processor operation: 1 accept, 2 threshold write, 3 EOI, 4 IPI write, 5 poll |
| op_arg | input | 32 | Operation argument |
| offer_done | output | 1 | An offer was answered |
| offer_taken | output | 1 | The answered offer was taken |
| rej_valid | output | 1 | A displaced source is handed back |
| rej_src | output | 24 | Rejected source number |
| eoi_valid | output | 1 | End-of-interrupt notice to the source bank |
| eoi_src | output | 24 | Source number being ended |
| resend_req | output | 1 | Ask the source bank to re-offer refused interrupts |
| rsp_valid | output | 1 | Response of accept or poll is valid |
| rsp_word | output | 32 | Threshold and presented source |
| rsp_ipi_prio | output | 8 | IPI priority |
| irq_out | output | 1 | Level interrupt request to the processor |

## Verification
The embedded assertions check several properties on every cycle. The slot is empty exactly when the pending priority is 0xff. A rejected or ended source is never the IPI. A taken offer was strictly more favored than all three priorities on the cycle before. Poll leaves the state untouched. A resend request leaves the refusal flag clear. The reset values are checked as well.

Some behaviours need the bench scenarios, because they depend on ordered sequences:
- the exact value of each displaced source;
- that equal priorities are refused;
- that an IPI is surfaced by a lowered threshold;
- that the refusal flag stays clear after offers of reserved numbers;
- that a refusal caused by a same-cycle conflict shows up in a later resend request.

// File: rtl/ipc_pkg.sv
package ipc_pkg;
    parameter int PRIO_W  = 8;
    parameter int SRC_W   = 24;
    parameter int WORD_W  = PRIO_W + SRC_W;
    parameter int OP_W    = 3;
    parameter int IPI_NUM = 2;

    typedef logic [PRIO_W-1:0] prio_t;
    typedef logic [SRC_W-1:0]  src_t;
    typedef logic [WORD_W-1:0] word_t;

    localparam prio_t PRIO_LEAST = '1;
    localparam src_t  SRC_IPI    = src_t'(IPI_NUM);

    typedef enum logic [OP_W-1:0] {
        OP_IDLE     = 3'd0,
        OP_ACCEPT   = 3'd1,
        OP_SET_THR  = 3'd2,
        OP_EOI      = 3'd3,
        OP_SET_IPI  = 3'd4,
        OP_POLL     = 3'd5
    } op_e;

    typedef struct packed {
        prio_t thr;          // current processor priority
        prio_t ipi;          // IPI request priority
        src_t  src;          // presented source, 0 = none
        prio_t pend;         // priority of presented source
        logic  need_resend;  // an offer was refused
    } slot_t;

    localparam slot_t SLOT_RESET = '{thr: '0, ipi: PRIO_LEAST, src: '0,
                                     pend: PRIO_LEAST, need_resend: 1'b0};

    function automatic logic is_ext_src(input src_t s);
        return (s != '0) && (s != SRC_IPI);
    endfunction

    function automatic word_t pack_word(input slot_t s);
        return {s.thr, s.src};
    endfunction
endpackage

// File: rtl/ipc_offer_eval.sv
module ipc_offer_eval
    import ipc_pkg::*;
(
    input  slot_t cur_st,
    input  logic  valid,
    input  src_t  src,
    input  prio_t prio,
    output slot_t nxt_st,
    output logic  take,
    output logic  rej_v,
    output src_t  rej_src
);
    logic beats_all;

    assign beats_all = (prio < cur_st.thr) && (prio < cur_st.ipi) &&
                       (prio < cur_st.pend);

    always_comb begin
        nxt_st  = cur_st;
        take    = 1'b0;
        rej_v   = 1'b0;
        rej_src = '0;
        if (valid && is_ext_src(src)) begin
            if (beats_all) begin
                take       = 1'b1;
                rej_v      = is_ext_src(cur_st.src);
                rej_src    = rej_v ? cur_st.src : '0;
                nxt_st.src = src;
                nxt_st.pend = prio;
            end else begin
                nxt_st.need_resend = 1'b1;
            end
        end
    end
endmodule

// File: rtl/ipc_op_exec.sv
module ipc_op_exec
    import ipc_pkg::*;
(
    input  slot_t cur_st,
    input  op_e   op,
    input  word_t arg,
    output slot_t nxt_st,
    output logic  state_op,
    output logic  rej_v,
    output src_t  rej_src,
    output logic  eoi_v,
    output src_t  eoi_src,
    output logic  resend,
    output logic  rsp_v,
    output word_t rsp_word,
    output prio_t rsp_ipi
);
    prio_t arg_prio;
    prio_t eoi_prio;
    src_t  arg_src;
    src_t  displaced;

    assign arg_prio = arg[PRIO_W-1:0];
    assign eoi_prio = arg[WORD_W-1 -: PRIO_W];
    assign arg_src  = arg[SRC_W-1:0];

    // threshold moves to a larger number: may surface the IPI, flushes resend
    function automatic slot_t lower_path(input slot_t s, input prio_t np);
        slot_t r;
        r     = s;
        r.thr = np;
        if ((s.ipi < np) && (s.ipi <= s.pend)) begin
            r.pend = s.ipi;
            r.src  = SRC_IPI;
        end
        r.need_resend = 1'b0;
        return r;
    endfunction

    always_comb begin
        nxt_st    = cur_st;
        state_op  = 1'b0;
        displaced = '0;
        eoi_v     = 1'b0;
        eoi_src   = '0;
        resend    = 1'b0;
        rsp_v     = 1'b0;
        rsp_word  = '0;
        rsp_ipi   = '0;
        case (op)
            OP_ACCEPT: begin
                state_op = 1'b1;
                rsp_v    = 1'b1;
                rsp_word = pack_word(cur_st);
                rsp_ipi  = cur_st.ipi;
                if (cur_st.src != '0) begin
                    nxt_st.thr  = cur_st.pend;
                    nxt_st.pend = PRIO_LEAST;
                    nxt_st.src  = '0;
                end
            end
            OP_POLL: begin
                rsp_v    = 1'b1;
                rsp_word = pack_word(cur_st);
                rsp_ipi  = cur_st.ipi;
            end
            OP_SET_THR: begin
                state_op = 1'b1;
                if (arg_prio > cur_st.thr) begin
                    nxt_st = lower_path(cur_st, arg_prio);
                    resend = cur_st.need_resend;
                end else if (arg_prio < cur_st.thr) begin
                    nxt_st.thr = arg_prio;
                    if (arg_prio <= cur_st.pend) begin
                        displaced   = cur_st.src;
                        nxt_st.src  = '0;
                        nxt_st.pend = PRIO_LEAST;
                    end
                end
            end
            OP_EOI: begin
                state_op = 1'b1;
                nxt_st   = lower_path(cur_st, eoi_prio);
                resend   = cur_st.need_resend;
                if (arg_src != SRC_IPI) begin
                    eoi_v   = 1'b1;
                    eoi_src = arg_src;
                end
            end
            OP_SET_IPI: begin
                state_op   = 1'b1;
                nxt_st.ipi = arg_prio;
                if (arg_prio < cur_st.thr) begin
                    if (arg_prio <= cur_st.pend)
                        displaced = cur_st.src;
                    nxt_st.pend = arg_prio;
                    nxt_st.src  = SRC_IPI;
                end
                if ((arg_prio > cur_st.ipi) && (arg_prio > cur_st.thr)) begin
                    resend             = cur_st.need_resend;
                    nxt_st.need_resend = 1'b0;
                end
            end
            default: ;
        endcase
    end

    assign rej_v   = is_ext_src(displaced);
    assign rej_src = rej_v ? displaced : '0;
endmodule

// File: rtl/irq_present_ctrl.sv
module irq_present_ctrl
    import ipc_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 offer_valid,
    input  logic [SRC_W-1:0]     offer_src,
    input  logic [PRIO_W-1:0]    offer_prio,
    input  logic [OP_W-1:0]      op_code,
    input  logic [WORD_W-1:0]    op_arg,
    output logic                 offer_done,
    output logic                 offer_taken,
    output logic                 rej_valid,
    output logic [SRC_W-1:0]     rej_src,
    output logic                 eoi_valid,
    output logic [SRC_W-1:0]     eoi_src,
    output logic                 resend_req,
    output logic                 rsp_valid,
    output logic [WORD_W-1:0]    rsp_word,
    output logic [PRIO_W-1:0]    rsp_ipi_prio,
    output logic                 irq_out
);
    slot_t st, st_nxt, off_nxt, op_nxt;
    logic  off_take, off_rej_v, op_state, op_rej_v;
    src_t  off_rej_src, op_rej_src;
    logic  op_eoi_v, op_resend, op_rsp_v;
    src_t  op_eoi_src;
    word_t op_rsp_word;
    prio_t op_rsp_ipi;
    logic  take_c, rej_v_c;
    src_t  rej_src_c;
    op_e   op;

    always_comb begin
        case (op_code)
            OP_ACCEPT:  op = OP_ACCEPT;
            OP_SET_THR: op = OP_SET_THR;
            OP_EOI:     op = OP_EOI;
            OP_SET_IPI: op = OP_SET_IPI;
            OP_POLL:    op = OP_POLL;
            default:    op = OP_IDLE;
        endcase
    end

    ipc_offer_eval u_offer (
        .cur_st  (st),
        .valid   (offer_valid),
        .src     (offer_src),
        .prio    (offer_prio),
        .nxt_st  (off_nxt),
        .take    (off_take),
        .rej_v   (off_rej_v),
        .rej_src (off_rej_src)
    );

    ipc_op_exec u_op (
        .cur_st   (st),
        .op       (op),
        .arg      (op_arg),
        .nxt_st   (op_nxt),
        .state_op (op_state),
        .rej_v    (op_rej_v),
        .rej_src  (op_rej_src),
        .eoi_v    (op_eoi_v),
        .eoi_src  (op_eoi_src),
        .resend   (op_resend),
        .rsp_v    (op_rsp_v),
        .rsp_word (op_rsp_word),
        .rsp_ipi  (op_rsp_ipi)
    );

    // a state-changing processor operation wins the cycle; the offer is refused
    always_comb begin
        if (op_state) begin
            st_nxt    = op_nxt;
            take_c    = 1'b0;
            rej_v_c   = op_rej_v;
            rej_src_c = op_rej_src;
            if (offer_valid && is_ext_src(offer_src))
                st_nxt.need_resend = 1'b1;
        end else begin
            st_nxt    = off_nxt;
            take_c    = off_take;
            rej_v_c   = off_rej_v;
            rej_src_c = off_rej_src;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st           <= SLOT_RESET;
            offer_done   <= 1'b0;
            offer_taken  <= 1'b0;
            rej_valid    <= 1'b0;
            rej_src      <= '0;
            eoi_valid    <= 1'b0;
            eoi_src      <= '0;
            resend_req   <= 1'b0;
            rsp_valid    <= 1'b0;
            rsp_word     <= '0;
            rsp_ipi_prio <= '0;
        end else begin
            st           <= st_nxt;
            offer_done   <= offer_valid;
            offer_taken  <= take_c;
            rej_valid    <= rej_v_c;
            rej_src      <= rej_src_c;
            eoi_valid    <= op_eoi_v;
            eoi_src      <= op_eoi_src;
            resend_req   <= op_resend;
            rsp_valid    <= op_rsp_v;
            rsp_word     <= op_rsp_word;
            rsp_ipi_prio <= op_rsp_ipi;
        end
    end

    assign irq_out = (st.src != '0) && (st.pend < st.thr);

    // ---------------- assertions ----------------
    assert_reset_state_R1: assert property (@(posedge clk)
        $past(rst) && !rst |-> (st.thr == '0) && (st.ipi == PRIO_LEAST) &&
                               (st.src == '0) && !st.need_resend);

    assert_take_rule_R2: assert property (@(posedge clk) disable iff (rst)
        offer_taken |-> $past(offer_valid) &&
                        ($past(offer_prio) < $past(st.thr)) &&
                        ($past(offer_prio) < $past(st.ipi)) &&
                        ($past(offer_prio) < $past(st.pend)));

    assert_reject_ext_only_R3: assert property (@(posedge clk) disable iff (rst)
        rej_valid |-> (rej_src != '0) && (rej_src != SRC_IPI));

    assert_slot_empty_consistent_R4: assert property (@(posedge clk) disable iff (rst)
        (st.src == '0) == (st.pend == PRIO_LEAST));

    assert_resend_flushes_R7: assert property (@(posedge clk) disable iff (rst)
        resend_req && !$past(offer_valid) |-> !st.need_resend);

    assert_eoi_not_ipi_R9: assert property (@(posedge clk) disable iff (rst)
        eoi_valid |-> eoi_src != SRC_IPI);

    assert_poll_stable_R10: assert property (@(posedge clk) disable iff (rst)
        (op_code == OP_POLL) && !offer_valid |=> $stable(st));
endmodule

// File: tb/irq_present_ctrl_bench.sv
module irq_present_ctrl_bench;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        offer_valid = 1'b0;
    logic [23:0] offer_src = '0;
    logic [7:0]  offer_prio = '0;
    logic [2:0]  op_code = '0;
    logic [31:0] op_arg = '0;
    logic        offer_done, offer_taken, rej_valid, eoi_valid, resend_req;
    logic        rsp_valid, irq_out;
    logic [23:0] rej_src, eoi_src;
    logic [31:0] rsp_word;
    logic [7:0]  rsp_ipi_prio;

    always #10 clk = ~clk;   // 50 MHz

    irq_present_ctrl u_irq_present_ctrl (
        .clk(clk), .rst(rst), .offer_valid(offer_valid), .offer_src(offer_src),
        .offer_prio(offer_prio), .op_code(op_code), .op_arg(op_arg),
        .offer_done(offer_done), .offer_taken(offer_taken),
        .rej_valid(rej_valid), .rej_src(rej_src),
        .eoi_valid(eoi_valid), .eoi_src(eoi_src), .resend_req(resend_req),
        .rsp_valid(rsp_valid), .rsp_word(rsp_word),
        .rsp_ipi_prio(rsp_ipi_prio), .irq_out(irq_out)
    );

    typedef struct packed {
        logic        od, ot, rv;
        logic [23:0] rs;
        logic        ev;
        logic [23:0] es;
        logic        rr, pv;
        logic [31:0] pw;
        logic [7:0]  pm;
        logic        irq;
    } obs_t;

    obs_t  exp_q[$];
    string tag_q[$];
    int    checks = 0;
    int    failures = 0;
    bit    finished = 0;

    // reference model state, built from the requirements
    logic [7:0]  m_thr = 8'h00, m_ipi = 8'hff, m_pend = 8'hff;
    logic [23:0] m_src = '0;
    logic        m_nr = 1'b0;

    task automatic m_lower(input logic [7:0] np, inout obs_t e);
        m_thr = np;
        if ((m_ipi < np) && (m_ipi <= m_pend)) begin
            m_pend = m_ipi;
            m_src  = 24'd2;
        end
        e.rr = m_nr;
        m_nr = 1'b0;
    endtask

    task automatic step(input logic ov, input logic [23:0] os, input logic [7:0] opr,
                        input logic [2:0] opc, input logic [31:0] arg, input string tag);
        obs_t e;
        logic ext;
        logic [7:0] np, old_ipi;
        logic [23:0] gone;
        @(negedge clk);
        offer_valid = ov; offer_src = os; offer_prio = opr;
        op_code = opc; op_arg = arg;
        e = '0; gone = '0;
        ext = ov && (os != 0) && (os != 2);
        e.od = ov;
        np = arg[7:0];
        case (opc)
            3'd1: begin
                e.pv = 1; e.pw = {m_thr, m_src}; e.pm = m_ipi;
                if (m_src != 0) begin m_thr = m_pend; m_pend = 8'hff; m_src = 0; end
            end
            3'd5: begin e.pv = 1; e.pw = {m_thr, m_src}; e.pm = m_ipi; end
            3'd2: begin
                if (np > m_thr) m_lower(np, e);
                else if (np < m_thr) begin
                    m_thr = np;
                    if (np <= m_pend) begin gone = m_src; m_src = 0; m_pend = 8'hff; end
                end
            end
            3'd3: begin
                m_lower(arg[31:24], e);
                if (arg[23:0] != 24'd2) begin e.ev = 1; e.es = arg[23:0]; end
            end
            3'd4: begin
                old_ipi = m_ipi; m_ipi = np;
                if (np < m_thr) begin
                    if (np <= m_pend) gone = m_src;
                    m_pend = np; m_src = 24'd2;
                end
                if ((np > old_ipi) && (np > m_thr)) begin e.rr = m_nr; m_nr = 0; end
            end
            default: ;
        endcase
        if (opc inside {3'd1, 3'd2, 3'd3, 3'd4}) begin
            if (ext) m_nr = 1;
        end else if (ext) begin
            if ((opr < m_thr) && (opr < m_ipi) && (opr < m_pend)) begin
                e.ot = 1; gone = m_src; m_src = os; m_pend = opr;
            end else m_nr = 1;
        end
        if ((gone != 0) && (gone != 2)) begin e.rv = 1; e.rs = gone; end
        e.irq = (m_src != 0) && (m_pend < m_thr);
        exp_q.push_back(e);
        tag_q.push_back(tag);
    endtask

    // monitor: compares each cycle's outputs with the oldest expected item
    initial begin
        forever begin
            @(posedge clk);
            #5;
            if (!rst && exp_q.size() > 0) begin
                obs_t a, e;
                string t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                a = '{od: offer_done, ot: offer_taken, rv: rej_valid, rs: rej_src,
                      ev: eoi_valid, es: eoi_src, rr: resend_req, pv: rsp_valid,
                      pw: rsp_word, pm: rsp_ipi_prio, irq: irq_out};
                checks++;
                if (a !== e) begin
                    failures++;
                    $display("FAIL %s actual=%h expected=%h", t, a, e);
                end
            end
        end
    end

    task automatic finish_run();
        if (!finished) begin
            finished = 1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    endtask

    initial begin
        repeat (5000) @(posedge clk);
        failures++;
        $display("FAIL watchdog expired actual=running expected=done");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // reset view through poll
        step(0, 0, 0, 3'd5, 0, "R1 reset state via poll");
        step(1, 24'd5, 8'h03, 0, 0, "R2 refused at zero threshold");
        step(0, 0, 0, 3'd2, 32'hff, "R7 lower threshold flushes resend");
        step(1, 24'd5, 8'h10, 0, 0, "R2 R4 offer taken, irq high");
        step(1, 24'd7, 8'h10, 0, 0, "R2 equal priority refused");
        step(1, 24'd7, 8'h08, 0, 0, "R3 better offer rejects source 5");
        step(0, 0, 0, 3'd2, 32'hff, "R6 same threshold does nothing");
        step(0, 0, 0, 3'd1, 0, "R5 accept presented source");
        step(0, 0, 0, 3'd1, 0, "R5 accept with empty slot");
        step(0, 0, 0, 3'd3, 32'hff000007, "R9 EOI notice and resend");
        step(1, 24'd0, 8'h01, 0, 0, "R2 source 0 refused");
        step(1, 24'd2, 8'h01, 0, 0, "R2 source 2 refused");
        step(0, 0, 0, 3'd3, 32'hff000002, "R9 IPI EOI silent, no resend");
        step(0, 0, 0, 3'd4, 32'h40, "R8 IPI presented");
        step(1, 24'd9, 8'h30, 0, 0, "R3 displaced IPI not reported");
        step(0, 0, 0, 3'd2, 32'h30, "R6 raise rejects source 9");
        step(0, 0, 0, 3'd4, 32'h50, "R8 IPI above threshold, no resend");
        step(1, 24'd11, 8'h35, 0, 0, "R2 refused above threshold");
        step(0, 0, 0, 3'd4, 32'h60, "R8 IPI growth flushes resend");
        step(0, 0, 0, 3'd2, 32'h70, "R7 lowering surfaces IPI");
        step(0, 0, 0, 3'd5, 0, "R10 poll");
        step(0, 0, 0, 3'd5, 0, "R10 poll unchanged");
        step(1, 24'd12, 8'h10, 3'd2, 32'h70, "R11 offer refused beside op");
        step(1, 24'd13, 8'h10, 3'd5, 0, "R11 offer taken beside poll");
        step(0, 0, 0, 3'd2, 32'hff, "R11 conflict refusal resent");
        step(0, 0, 0, 3'd4, 32'h05, "R8 IPI rejects source 13");
        step(0, 0, 0, 3'd6, 32'h01, "R12 unused code ignored");
        step(0, 0, 0, 3'd5, 0, "R12 state after unused code");
        step(0, 0, 0, 3'd1, 0, "R5 accept IPI");
        step(0, 0, 0, 3'd0, 0, "R12 idle cycle");
        @(negedge clk);
        offer_valid = 0; op_code = 0; op_arg = 0;
        repeat (3) @(negedge clk);
        if (exp_q.size() != 0) begin
            checks++;
            failures++;
            $display("FAIL R12 leftover items actual=%0d expected=0", exp_q.size());
        end
        finish_run();
    end
endmodule